// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which pending interrupt line, if any, should be presented to the processor. It takes the pending-request vector, the mask vector and the in-service vector of an eight-line interrupt controller, plus a rotation offset. It first finds the best unmasked pending line under a rotating priority order. The line at the offset position ranks highest, and priority falls as the index rises, wrapping around.

That candidate is then compared with the best line already in service, ranked under the same order. A request is raised only when the candidate strictly outranks every in-service line. When the instance is built as the master of a cascade and the special nested mode input is high, the cascade line is left out of the in-service ranking. This lets a second request arriving through the cascade interrupt a handler that is already running for that cascade.

The resolver is pure combinational logic made of a rotate stage and a first-set encoder, with no iteration. A parameter adds an output register. The registers that feed it, the acknowledge sequencing and vector formation sit outside the block. All pins are plain level signals: the outputs are status and are recomputed whenever the inputs change, so there is no handshake and no back-pressure.

Top module: `rot_prio_resolver`

## Requirements
- R1: The candidate set is `pend_i & ~mask_i`. A line whose mask bit is 1 is never reported on `irq_o` while `req_o` is 1.
- R2: The rank of a line `n` is `(n - rot_off_i) mod 8`, and rank 0 is the highest. The candidate is the set line with the smallest rank, and `irq_o` carries its line index (rank + offset) mod 8.
- R3: `req_o` is 1 only when the candidate's rank is strictly less than the smallest rank among the set bits of the in-service vector. An equal rank or a worse rank gives `req_o` = 0. An empty in-service vector counts as rank 8, which any candidate beats.
- R4: When the candidate set is empty, `req_o` is 0.
- R5: With parameter `IS_MASTER` = 1 and `nest_en_i` = 1, bit `CASCADE_LINE` (default 2) of `insvc_i` is ignored when ranking the in-service vector. With `nest_en_i` = 0 that bit counts like any other.
- R6: `irq_o` is 0 whenever `req_o` is 0.
- R7: With `REG_OUT` = 1 (default), `req_o` and `irq_o` show the result for the inputs present at the previous rising clock edge, and both are 0 while `rst_n` is low. With `REG_OUT` = 0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| pend_i | input | LINES | Pending-request vector |
| mask_i | input | LINES | Mask vector, 1 = line masked |
| insvc_i | input | LINES | In-service vector |
| rot_off_i | input | IDX_W | Rotation offset; this line index ranks highest |
| nest_en_i | input | 1 | Special nested mode enable (effective only when IS_MASTER = 1) |
| req_o | output | 1 | Interrupt request to the processor |
| irq_o | output | IDX_W | Line index of the winning request, 0 when no request |

## Verification
The bench aims at the wrap of the rotated order. It sets the highest and lowest line indices pending under a non-zero offset, and a design that ranked by plain index would pick the wrong line there. It covers a candidate of equal rank to an in-service line, where a non-strict comparison would raise a spurious request. It also covers an offset of 7 with the in-service line at index 7, where a design that forgot to rotate the in-service vector would let line 0 through. It toggles the nested enable with only the cascade line in service, where a design that always masked it would interrupt its own handler and a design that never masked it would block a nested cascade request. Several thousand random input sets are then compared against an independent loop-based model.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int unsigned PR_DEF_LINES   = 8;
  localparam int unsigned PR_DEF_CASCADE = 2;
endpackage

// File: rtl/pr_rotator.sv
// Rotates a line vector so that position 0 holds line `off`.
module pr_rotator #(
  parameter int unsigned LINES = pr_pkg::PR_DEF_LINES,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] vec_i,
  input  logic [IDX_W-1:0] off_i,
  output logic [LINES-1:0] rot_o
);
  logic [2*LINES-1:0] doubled;
  logic [2*LINES-1:0] shifted;

  assign doubled = {vec_i, vec_i};
  assign shifted = doubled >> off_i;
  assign rot_o   = shifted[LINES-1:0];
endmodule

// File: rtl/pr_first_set.sv
// Finds the lowest set position of a vector; an empty vector yields LINES.
module pr_first_set #(
  parameter int unsigned LINES = pr_pkg::PR_DEF_LINES,
  localparam int unsigned RANK_W = $clog2(LINES + 1)
) (
  input  logic [LINES-1:0]  vec_i,
  output logic [LINES-1:0]  first_o,
  output logic [RANK_W-1:0] rank_o
);
  logic [LINES:0] seen;

  assign seen[0] = 1'b0;
  for (genvar k = 0; k < LINES; k++) begin : g_chain
    assign first_o[k]  = vec_i[k] & ~seen[k];
    assign seen[k+1]   = seen[k] | vec_i[k];
  end

  always_comb begin
    rank_o = RANK_W'(LINES);
    for (int k = 0; k < LINES; k++) begin
      if (first_o[k]) rank_o = RANK_W'(k);
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int unsigned LINES        = pr_pkg::PR_DEF_LINES,
  parameter int unsigned CASCADE_LINE = pr_pkg::PR_DEF_CASCADE,
  parameter bit          IS_MASTER    = 1'b1,
  parameter bit          REG_OUT      = 1'b1,
  localparam int unsigned IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned RANK_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] insvc_i,
  input  logic [IDX_W-1:0] rot_off_i,
  input  logic             nest_en_i,
  output logic             req_o,
  output logic [IDX_W-1:0] irq_o
);
  logic [LINES-1:0]  cand;
  logic [LINES-1:0]  svc_eff;
  logic [LINES-1:0]  cand_rot;
  logic [LINES-1:0]  svc_rot;
  logic [LINES-1:0]  cand_first;
  logic [LINES-1:0]  svc_first;
  logic [RANK_W-1:0] cand_rank;
  logic [RANK_W-1:0] svc_rank;
  logic              req_c;
  logic [IDX_W-1:0]  line_c;
  logic [IDX_W-1:0]  irq_c;

  assign cand = pend_i & ~mask_i;

  // Cascade line drops out of the in-service ranking in nested mode.
  if (IS_MASTER) begin : g_master
    always_comb begin
      svc_eff = insvc_i;
      if (nest_en_i) svc_eff[CASCADE_LINE] = 1'b0;
    end
  end else begin : g_slave
    assign svc_eff = insvc_i;
  end

  pr_rotator #(.LINES(LINES)) u_rot_cand (
    .vec_i(cand), .off_i(rot_off_i), .rot_o(cand_rot)
  );
  pr_rotator #(.LINES(LINES)) u_rot_svc (
    .vec_i(svc_eff), .off_i(rot_off_i), .rot_o(svc_rot)
  );
  pr_first_set #(.LINES(LINES)) u_fs_cand (
    .vec_i(cand_rot), .first_o(cand_first), .rank_o(cand_rank)
  );
  pr_first_set #(.LINES(LINES)) u_fs_svc (
    .vec_i(svc_rot), .first_o(svc_first), .rank_o(svc_rank)
  );

  assign req_c = (cand_rank < svc_rank);

  always_comb begin
    int s;
    s = int'(cand_rank) + int'(rot_off_i);
    if (s >= int'(LINES)) s = s - int'(LINES);
    line_c = IDX_W'(s);
  end

  assign irq_c = req_c ? line_c : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_o <= 1'b0;
        irq_o <= '0;
      end else begin
        req_o <= req_c;
        irq_o <= irq_c;
      end
    end
  end else begin : g_comb
    assign req_o = req_c;
    assign irq_o = irq_c;
  end

  // R1
  masked_never_won_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_c |-> (pend_i[irq_c] && !mask_i[irq_c]));
  // R3
  winner_not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_c |-> !svc_eff[irq_c]);
  // R4
  empty_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !req_c);
  // R2
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cand_first) && $onehot0(svc_first));
  // R6
  idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (irq_o == '0));
  // R5
  nest_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MASTER && nest_en_i && insvc_i == (LINES'(1) << CASCADE_LINE)
     && cand != '0) |-> req_c);
endmodule

// File: tb/rot_prio_resolver_bench.sv
module rot_prio_resolver_bench;
  localparam int unsigned N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend = '0, mask = '0, insvc = '0;
  logic [2:0] off = '0;
  logic       nest = 1'b0;
  logic       req;
  logic [2:0] irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rot_prio_resolver u_rot_prio_resolver (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .insvc_i(insvc),
    .rot_off_i(off), .nest_en_i(nest), .req_o(req), .irq_o(irq)
  );

  // Fields: pend, mask, insvc, offset, nest, expected req, expected irq
  localparam logic [31:0] VEC [13] = '{
    {8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd0},  // R2 plain order
    {8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b1, 3'd7},  // R2 wrap, 7 beats 0
    {8'h81, 8'h80, 8'h00, 3'd1, 1'b0, 1'b1, 3'd0},  // R1 mask removes 7
    {8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 3'd0},  // R4 all masked
    {8'h10, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 3'd0},  // R3 equal rank
    {8'h08, 8'h00, 8'h10, 3'd0, 1'b0, 1'b1, 3'd3},  // R3 strictly better
    {8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 3'd2},  // R5 cascade ignored
    {8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 3'd0},  // R5 cascade counted
    {8'h20, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 3'd5},  // R5 nested, line 5
    {8'h20, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 3'd0},  // R5 no nesting
    {8'h01, 8'h00, 8'h80, 3'd7, 1'b0, 1'b0, 3'd0},  // R3 rotated in-service
    {8'h09, 8'h00, 8'h00, 3'd4, 1'b0, 1'b1, 3'd0},  // R2 offset 4
    {8'h00, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 3'd0}   // R4 empty
  };

  function automatic void model(input logic [7:0] p, m, s, input logic [2:0] o,
                                input logic ne, output logic r, output logic [2:0] q);
    int pc = 8, ps = 8;
    logic [7:0] c = p & ~m;
    logic [7:0] se = s;
    if (ne) se[2] = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      if (c[(k + o) % 8]) pc = k;
      if (se[(k + o) % 8]) ps = k;
    end
    r = (pc < ps);
    q = r ? 3'((pc + o) % 8) : 3'd0;
  endfunction

  task automatic check(input string tag, input logic er, input logic [2:0] ei);
    checks++;
    if (req !== er || irq !== ei) begin
      errors++;
      $display("FAIL %s: req=%0b irq=%0d expected req=%0b irq=%0d",
               tag, req, irq, er, ei);
    end
  endtask

  task automatic apply(input logic [7:0] p, m, s, input logic [2:0] o, input logic ne);
    @(negedge clk);
    pend = p; mask = m; insvc = s; off = o; nest = ne;
    @(negedge clk);  // one register stage: result visible after next edge
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic er;
    logic [2:0] ei;
    // R7 reset holds outputs at zero even with a winning request present
    pend = 8'hFF;
    repeat (3) @(negedge clk);
    check("R7 reset", 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after reset, line 0 wins", 1'b1, 3'd0);

    // table walk
    for (int i = 0; i < 13; i++) begin
      apply(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:5], VEC[i][4]);
      check($sformatf("R2/R3 vector %0d", i), VEC[i][3], VEC[i][2:0]);
    end

    // R7 one-cycle latency: outputs still show old result just after the edge
    @(negedge clk);
    pend = 8'h40; mask = 8'h00; insvc = 8'h00; off = 3'd0; nest = 1'b0;
    check("R7 latency, before edge", 1'b0, 3'd0);
    @(negedge clk);
    check("R7 latency, after edge", 1'b1, 3'd6);

    // R6 index returns to zero after a request goes away
    apply(8'h40, 8'h40, 8'h00, 3'd0, 1'b0);
    check("R6 index cleared", 1'b0, 3'd0);

    // R1..R5 random comparison against the loop model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] p, m, s;
      logic [2:0] o;
      logic ne;
      p = 8'($urandom); m = 8'($urandom & $urandom); s = 8'($urandom & $urandom);
      o = 3'($urandom); ne = 1'($urandom);
      model(p, m, s, o, ne, er, ei);
      apply(p, m, s, o, ne);
      check("R1-model random", er, ei);
    end

    done = 1'b1;
    finish_run();
  end
endmodule